// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Sequencing

This block keeps an EDO DRAM refreshed using CAS-before-RAS refresh cycles, in which the DRAM's own row counter supplies the row. A programmable interval timer accrues a refresh debt, one unit per elapsed interval, and raises `ref_req` toward the access controller while any debt is outstanding. When the controller answers with `ref_grant`, the block takes the RAS and CAS strobes, settles one unit of debt and plays out the refresh pin sequence: CAS low first, then RAS low, then both high for precharge. If the grant is withheld, the debt keeps growing. Once it reaches a programmable limit, `ref_urgent` tells the controller to stop deferring.

On `sr_enter` the block runs the same CAS-first entry and then keeps both strobes low. After the programmed minimum low time it reports `sr_active`. From then on the DRAM refreshes itself. `sr_exit` is honoured only once that minimum has elapsed. The block then drives RAS high for the programmed recovery time. If the controller had been refreshing in bursts (`cfg_burst_mode` = 1), a programmed number of back-to-back refresh cycles follows before the strobes are released. In distributed mode the strobes are released at once. All DRAM timings are counted in clock cycles.

The state machine has eight states. ST_IDLE owns no pins. ST_CBR_CAS, ST_CBR_RAS and ST_CBR_PRE form one refresh cycle. ST_SR_CAS, ST_SR_HOLD, ST_SR_ON and ST_SR_EXIT form self-refresh. The transitions are:
- ST_IDLE→ST_SR_CAS on `sr_enter`.
- ST_IDLE→ST_CBR_CAS on a grant while debt is outstanding.
- ST_CBR_CAS→ST_CBR_RAS and ST_CBR_RAS→ST_CBR_PRE when each state's timer expires.
- ST_CBR_PRE→ST_CBR_CAS while burst cycles remain, otherwise ST_CBR_PRE→ST_IDLE.
- ST_SR_CAS→ST_SR_HOLD and ST_SR_HOLD→ST_SR_ON when each state's timer expires.
- ST_SR_ON→ST_SR_EXIT on `sr_exit`.
- ST_SR_EXIT→ST_CBR_CAS in burst mode, or ST_SR_EXIT→ST_IDLE in distributed mode.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n` and `cas_n` are 1, and `ref_req`, `ref_urgent`, `pins_owned` and `sr_active` are 0.
- R2: With no grant, the debt rises by one every `cfg_interval` cycles, counted from reset release. The first `ref_req` appears exactly `cfg_interval` clock edges after reset release.
- R3: `ref_urgent` is 1 exactly when the debt is nonzero and at least `cfg_urgent_lim`.
- R4: A grant is accepted only in ST_IDLE with nonzero debt. Each accepted grant removes one unit of debt. `ref_req` falls once the debt is zero. A grant held high with no debt leaves the strobes high.
- R5: A refresh cycle holds `cas_n`=0, `ras_n`=1 for T_CSR cycles, then both at 0 for T_RAS cycles, then both at 1 for T_RP cycles. `pins_owned` is 1 throughout. One idle cycle separates cycles started by separate grants.
- R6: `ras_n` never falls unless `cas_n` was already 0 in the previous cycle and is still 0.
- R7: After `sr_enter` in ST_IDLE, the block holds `cas_n`=0 with `ras_n`=1 for T_CSR cycles, then both at 0 for `cfg_sr_hold` cycles with `sr_active`=0. After that it holds both at 0 with `sr_active`=1.
- R8: `sr_exit` has no effect before `sr_active` is 1. After an accepted exit, both strobes are 1 for `cfg_sr_exit` cycles with `sr_active`=0.
- R9: In distributed mode (`cfg_burst_mode`=0), the strobes are released right after the exit high time. In burst mode (`cfg_burst_mode`=1), `cfg_burst_len` back-to-back refresh cycles follow first, with no idle cycle between them.
- R10: From self-refresh entry until the strobes are released, `ref_req` is 0 and the debt and interval timer are cleared. The next `ref_req` comes exactly `cfg_interval` edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_interval | input | IW | Cycles per refresh interval |
| cfg_urgent_lim | input | DW | Debt at which urgency is flagged |
| cfg_sr_hold | input | TW | Minimum strobe-low cycles in self-refresh |
| cfg_sr_exit | input | TW | RAS-high cycles after leaving self-refresh |
| cfg_burst_len | input | BW | Refresh cycles in the post-exit burst |
| cfg_burst_mode | input | 1 | 1: burst refresh was in use, so catch up after exit |
| ref_grant | input | 1 | Access controller releases the strobes |
| sr_enter | input | 1 | Request to enter self-refresh (sampled in idle) |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh debt outstanding |
| ref_urgent | output | 1 | Debt has reached the limit |
| pins_owned | output | 1 | Block is driving the strobes |
| sr_active | output | 1 | DRAM is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The bench builds the block with an 8-bit interval timer, a 4-bit debt, 4-bit delay timers, a 3-bit burst counter, and T_CSR=2, T_RAS=3, T_RP=2. These narrow fields keep every sweep to a few dozen cycles per point. That makes it possible to cover every combination of hold time, exit time and burst length from 1 to 3, in both exit modes, with both early and late exit requests. It also sweeps every urgency limit from 1 to 4 and several interval lengths, comparing cycle by cycle against edge counts worked out arithmetically.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CBR_PRE,
        ST_SR_CAS,
        ST_SR_HOLD,
        ST_SR_ON,
        ST_SR_EXIT
    } drs_state_e;

    // Row strobe is low while the row is held in refresh.
    function automatic logic st_ras_low(input drs_state_e st);
        return (st == ST_CBR_RAS) || (st == ST_SR_HOLD) || (st == ST_SR_ON);
    endfunction

    // Column strobe leads the row strobe and stays low under it.
    function automatic logic st_cas_low(input drs_state_e st);
        return (st == ST_CBR_CAS) || (st == ST_CBR_RAS) || (st == ST_SR_CAS) ||
               (st == ST_SR_HOLD) || (st == ST_SR_ON);
    endfunction

    function automatic logic st_self(input drs_state_e st);
        return (st == ST_SR_CAS) || (st == ST_SR_HOLD) || (st == ST_SR_ON) ||
               (st == ST_SR_EXIT);
    endfunction

endpackage

// File: rtl/drs_interval_ctr.sv
module drs_interval_ctr #(
    parameter int IW = 16,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] cfg_interval,
    input  logic [DW-1:0] cfg_urgent_lim,
    input  logic          hold,
    input  logic          take,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          have_debt
);

    localparam logic [DW-1:0] DEBT_MAX = '1;

    logic [IW-1:0] cnt;
    logic [IW-1:0] last;
    logic [DW-1:0] debt;
    logic          tick;

    always_comb begin
        last = (cfg_interval == '0) ? '0 : cfg_interval - IW'(1);
        tick = !hold && (cnt >= last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            debt <= '0;
        end else if (hold) begin
            cnt  <= '0;
            debt <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + IW'(1);
            if (tick && !take && debt != DEBT_MAX)
                debt <= debt + DW'(1);
            else if (!tick && take)
                debt <= debt - DW'(1);
        end
    end

    assign have_debt  = (debt != '0);
    assign ref_req    = have_debt && !hold;
    assign ref_urgent = ref_req && (debt >= cfg_urgent_lim);

    // R2: debt moves by one step at a time, or is cleared
    a_r2_debt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(debt) |-> (debt == $past(debt) + DW'(1)) ||
                           (debt == $past(debt) - DW'(1)) || (debt == '0));

    // R10: self-refresh clears the outstanding debt
    a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !have_debt);

endmodule

// File: rtl/drs_pin_fsm.sv
module drs_pin_fsm
    import drs_pkg::*;
#(
    parameter int TW    = 8,
    parameter int BW    = 8,
    parameter int T_CSR = 1,
    parameter int T_RAS = 4,
    parameter int T_RP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_grant,
    input  logic          have_debt,
    input  logic          sr_enter,
    input  logic          sr_exit,
    input  logic [TW-1:0] cfg_sr_hold,
    input  logic [TW-1:0] cfg_sr_exit,
    input  logic [BW-1:0] cfg_burst_len,
    input  logic          cfg_burst_mode,
    output logic          take,
    output logic          hold,
    output logic          ras_n,
    output logic          cas_n,
    output logic          pins_owned,
    output logic          sr_active
);

    localparam logic [TW-1:0] L_CSR = TW'(T_CSR - 1);
    localparam logic [TW-1:0] L_RAS = TW'(T_RAS - 1);
    localparam logic [TW-1:0] L_RP  = TW'(T_RP - 1);

    drs_state_e    state, state_nxt;
    logic [TW-1:0] tmr, tmr_nxt;
    logic [BW-1:0] brem, brem_nxt;
    logic          burst, burst_nxt;

    function automatic logic [TW-1:0] ld_t(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    // next-state decision
    always_comb begin
        state_nxt = state;
        tmr_nxt   = (tmr == '0) ? '0 : tmr - TW'(1);
        brem_nxt  = brem;
        burst_nxt = burst;
        take      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sr_enter) begin
                    state_nxt = ST_SR_CAS;
                    tmr_nxt   = L_CSR;
                end else if (ref_grant && have_debt) begin
                    state_nxt = ST_CBR_CAS;
                    tmr_nxt   = L_CSR;
                    take      = 1'b1;
                end
            end
            ST_CBR_CAS: if (tmr == '0) begin
                state_nxt = ST_CBR_RAS;
                tmr_nxt   = L_RAS;
            end
            ST_CBR_RAS: if (tmr == '0) begin
                state_nxt = ST_CBR_PRE;
                tmr_nxt   = L_RP;
            end
            ST_CBR_PRE: if (tmr == '0) begin
                if (burst && brem != '0) begin
                    state_nxt = ST_CBR_CAS;
                    tmr_nxt   = L_CSR;
                    brem_nxt  = brem - BW'(1);
                end else begin
                    state_nxt = ST_IDLE;
                    burst_nxt = 1'b0;
                end
            end
            ST_SR_CAS: if (tmr == '0) begin
                state_nxt = ST_SR_HOLD;
                tmr_nxt   = ld_t(cfg_sr_hold);
            end
            ST_SR_HOLD: if (tmr == '0) begin
                state_nxt = ST_SR_ON;
            end
            ST_SR_ON: if (sr_exit) begin
                state_nxt = ST_SR_EXIT;
                tmr_nxt   = ld_t(cfg_sr_exit);
            end
            ST_SR_EXIT: if (tmr == '0) begin
                if (cfg_burst_mode) begin
                    state_nxt = ST_CBR_CAS;
                    tmr_nxt   = L_CSR;
                    burst_nxt = 1'b1;
                    brem_nxt  = (cfg_burst_len == '0) ? '0 : cfg_burst_len - BW'(1);
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
            brem  <= '0;
            burst <= 1'b0;
        end else begin
            state <= state_nxt;
            tmr   <= tmr_nxt;
            brem  <= brem_nxt;
            burst <= burst_nxt;
        end
    end

    // registered pin and status outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n      <= 1'b1;
            cas_n      <= 1'b1;
            pins_owned <= 1'b0;
            sr_active  <= 1'b0;
        end else begin
            ras_n      <= !st_ras_low(state_nxt);
            cas_n      <= !st_cas_low(state_nxt);
            pins_owned <= (state_nxt != ST_IDLE);
            sr_active  <= (state_nxt == ST_SR_ON);
        end
    end

    assign hold = burst || st_self(state);

    // R6: row strobe only falls under an already-low column strobe
    a_r6_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    a_r6_cas_held_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);

    // R8: leaving self-refresh raises both strobes
    a_r8_exit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int IW    = 16,
    parameter int DW    = 4,
    parameter int TW    = 8,
    parameter int BW    = 8,
    parameter int T_CSR = 1,
    parameter int T_RAS = 4,
    parameter int T_RP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] cfg_interval,
    input  logic [DW-1:0] cfg_urgent_lim,
    input  logic [TW-1:0] cfg_sr_hold,
    input  logic [TW-1:0] cfg_sr_exit,
    input  logic [BW-1:0] cfg_burst_len,
    input  logic          cfg_burst_mode,
    input  logic          ref_grant,
    input  logic          sr_enter,
    input  logic          sr_exit,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          pins_owned,
    output logic          sr_active,
    output logic          ras_n,
    output logic          cas_n
);

    logic take;
    logic hold;
    logic have_debt;

    drs_interval_ctr #(.IW(IW), .DW(DW)) ctr_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_interval   (cfg_interval),
        .cfg_urgent_lim (cfg_urgent_lim),
        .hold           (hold),
        .take           (take),
        .ref_req        (ref_req),
        .ref_urgent     (ref_urgent),
        .have_debt      (have_debt)
    );

    drs_pin_fsm #(
        .TW(TW), .BW(BW), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_grant      (ref_grant),
        .have_debt      (have_debt),
        .sr_enter       (sr_enter),
        .sr_exit        (sr_exit),
        .cfg_sr_hold    (cfg_sr_hold),
        .cfg_sr_exit    (cfg_sr_exit),
        .cfg_burst_len  (cfg_burst_len),
        .cfg_burst_mode (cfg_burst_mode),
        .take           (take),
        .hold           (hold),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .pins_owned     (pins_owned),
        .sr_active      (sr_active)
    );

    // R10: no refresh request while the DRAM refreshes itself
    a_r10_sr_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !ref_req);

    // R3: urgency is never flagged without an outstanding request
    a_r3_urgent_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

    localparam int IW = 8, DW = 4, TW = 4, BW = 3;
    localparam int T_CSR = 2, T_RAS = 3, T_RP = 2;
    localparam int CYC = T_CSR + T_RAS + T_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic [IW-1:0] cfg_interval = 8'd10;
    logic [DW-1:0] cfg_urgent_lim = 4'd2;
    logic [TW-1:0] cfg_sr_hold = 4'd1;
    logic [TW-1:0] cfg_sr_exit = 4'd1;
    logic [BW-1:0] cfg_burst_len = 3'd1;
    logic cfg_burst_mode = 1'b0;
    logic ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ref_req, ref_urgent, pins_owned, sr_active, ras_n, cas_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_refresh_sched #(
        .IW(IW), .DW(DW), .TW(TW), .BW(BW),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
        .cfg_urgent_lim(cfg_urgent_lim), .cfg_sr_hold(cfg_sr_hold),
        .cfg_sr_exit(cfg_sr_exit), .cfg_burst_len(cfg_burst_len),
        .cfg_burst_mode(cfg_burst_mode), .ref_grant(ref_grant),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .pins_owned(pins_owned),
        .sr_active(sr_active), .ras_n(ras_n), .cas_n(cas_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sample n cycles; the vector is {ras_n,cas_n,pins_owned,sr_active,ref_req}.
    // sr_enter is a one-cycle pulse, so it is dropped after every sample.
    task automatic seg(input bit er, ec, eo, es, eq, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            sr_enter = 1'b0;
            chk({ras_n, cas_n, pins_owned, sr_active, ref_req} == {er, ec, eo, es, eq},
                tag, int'({ras_n, cas_n, pins_owned, sr_active, ref_req}),
                int'({er, ec, eo, es, eq}));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_grant = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({ras_n, cas_n, ref_req, ref_urgent, pins_owned, sr_active} == 6'b110000,
            "R1 reset outputs",
            int'({ras_n, cas_n, ref_req, ref_urgent, pins_owned, sr_active}), 48);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // count edges until ref_req is seen high
    task automatic wait_req(input int exp, input string tag);
        int n = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (ref_req) break;
        end
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        // R2: first request after exactly cfg_interval edges
        for (int iv = 2; iv <= 6; iv++) begin
            cfg_interval = IW'(iv);
            do_reset();
            wait_req(iv, "R2 first request delay");
        end

        // R2/R3: debt growth and urgency over every limit
        for (int lim = 1; lim <= 4; lim++) begin
            cfg_interval = 8'd3;
            cfg_urgent_lim = DW'(lim);
            do_reset();
            for (int n = 1; n <= 15; n++) begin
                @(posedge clk);
                @(negedge clk);
                chk(ref_req == ((n / 3) > 0), "R2 request from debt", ref_req, int'((n / 3) > 0));
                chk(ref_urgent == ((n / 3) >= lim), "R3 urgent at limit", ref_urgent,
                    int'((n / 3) >= lim));
            end
        end

        // R4/R5: pin sequence, grant ignored without debt, then next grant
        for (int iv = 9; iv <= 11; iv++) begin
            cfg_interval = IW'(iv);
            cfg_urgent_lim = 4'd1;
            do_reset();
            wait_req(iv, "R2 request before grant");
            ref_grant = 1'b1;
            seg(1, 0, 1, 0, 0, T_CSR, "R5 cas setup");
            seg(0, 0, 1, 0, 0, T_RAS, "R5 both low");
            seg(1, 1, 1, 0, 0, T_RP, "R5 precharge");
            seg(1, 1, 0, 0, 0, iv - CYC - 1, "R4 grant without debt ignored");
            seg(1, 1, 0, 0, 1, 1, "R4 new debt raises request");
            seg(1, 0, 1, 0, 0, T_CSR, "R4 second grant accepted");
            seg(0, 0, 1, 0, 0, T_RAS, "R5 second cycle low");
            ref_grant = 1'b0;
            seg(1, 1, 1, 0, 0, T_RP, "R5 second precharge");
        end

        // R4: three units of debt are paid with three cycles
        begin
            int falls = 0;
            logic prev;
            cfg_interval = 8'd5;
            do_reset();
            repeat (15) @(posedge clk);
            @(negedge clk);
            chk(ref_req == 1'b1, "R4 debt pending", ref_req, 1);
            cfg_interval = 8'd200;
            ref_grant = 1'b1;
            prev = ras_n;
            for (int i = 0; i < 30; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (prev && !ras_n) falls++;
                prev = ras_n;
            end
            chk(falls == 3, "R4 one cycle per debt unit", falls, 3);
            chk(!ref_req && !pins_owned && ras_n, "R4 request cleared",
                int'({ref_req, pins_owned, ras_n}), 1);
            ref_grant = 1'b0;
        end

        // R7-R10: self-refresh sweep
        for (int mode = 0; mode <= 1; mode++)
            for (int early = 0; early <= 1; early++)
                for (int hd = 1; hd <= 3; hd++)
                    for (int ex = 1; ex <= 3; ex++)
                        for (int bl = 1; bl <= (mode ? 3 : 1); bl++) begin
                            cfg_interval = 8'd7;
                            cfg_burst_mode = mode[0];
                            cfg_sr_hold = TW'(hd);
                            cfg_sr_exit = TW'(ex);
                            cfg_burst_len = BW'(bl);
                            do_reset();
                            sr_exit = early[0];
                            sr_enter = 1'b1;
                            seg(1, 0, 1, 0, 0, T_CSR, "R7 entry cas setup");
                            seg(0, 0, 1, 0, 0, hd, "R7 R8 hold, exit ignored");
                            if (early) begin
                                seg(0, 0, 1, 1, 0, 1, "R7 active one cycle");
                            end else begin
                                seg(0, 0, 1, 1, 0, 3, "R7 active held");
                                sr_exit = 1'b1;
                            end
                            seg(1, 1, 1, 0, 0, ex, "R8 exit high time");
                            sr_exit = 1'b0;
                            if (mode) begin
                                for (int b = 0; b < bl; b++) begin
                                    seg(1, 0, 1, 0, 0, T_CSR, "R9 burst cas setup");
                                    seg(0, 0, 1, 0, 0, T_RAS, "R9 burst low");
                                    seg(1, 1, 1, 0, 0, T_RP, "R9 burst precharge");
                                end
                            end
                            seg(1, 1, 0, 0, 0, 1, "R9 released");
                            wait_req(7, "R10 timer restarts after release");
                        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule